// File: doc/BRIEF.md
# Pulse Interval Sample Recorder

This block follows a capture timer channel. Each time the channel finishes a capture, it sends the recorder a one-cycle pulse with the 16-bit count it captured and a flag that shows whether the counter wrapped since the previous capture. After it is armed, the recorder collects a fixed number of these interval measurements into a small register-file buffer. It then stops listening and raises a done flag.

The count that comes with the first capture after arming measures time back to the start of counting, not a full pulse interval, so the recorder drops it. Storage begins with the second capture. The buffer fills from its highest slot downward.

A mode input, latched at arming, selects the entry format. Compact entries hold the 16-bit interval and write zero when the counter wrapped. Extended entries hold a 17-bit value: the wrap flag becomes bit 16, so an interval with one wrap is still recorded. Any slot can be read at any time through an index-addressed read port.

Top module: `pulse_interval_recorder`

## Requirements
- R1: After reset, done and listening are 0 and every buffer slot reads zero.
- R2: A cycle with arm high clears every slot to zero and reloads the remaining count to DEPTH (8). From the next cycle, listening is 1 and done is 0. This holds in any state.
- R3: The first capture pulse after arming changes no slot and does not reduce the remaining count.
- R4: The k-th stored measurement (k = 1..DEPTH) is written to slot DEPTH-k. The first lands in slot 7 and the eighth in slot 0. Each write is readable on rd_entry in the cycle after the capture pulse.
- R5: In compact mode (ext_mode = 0 at arming), a capture with cap_ovf = 1 stores 17'h00000. Otherwise the slot holds {1'b0, cap_value}. Boundary values 0006h and FFFFh are stored unchanged.
- R6: In extended mode (ext_mode = 1 at arming), the slot holds {cap_ovf, cap_value}, that is a 17-bit value with the wrap flag in bit 16.
- R7: In the cycle after the DEPTH-th stored measurement, done rises and listening falls. done and listening are never 1 together, and done stays 1 until the next arm.
- R8: A capture pulse while idle (before any arm) or while done changes no slot and no flag.
- R9: The storage format is fixed by ext_mode at the arm cycle. Changes on ext_mode during a run have no effect on how entries are formatted.
- R10: When arm and a capture pulse arrive in the same cycle, arm wins. The capture is dropped, and the next capture is treated as the first one after arming, so it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse: clear the buffer and start a run |
| ext_mode | input | 1 | Entry format sampled at arm: 0 compact, 1 extended |
| cap_valid | input | 1 | One-cycle capture-complete pulse from the timer channel |
| cap_value | input | VAL_W (16) | Captured interval count |
| cap_ovf | input | 1 | Counter wrapped since the previous capture |
| rd_idx | input | IDX_W (3) | Slot index for the read port |
| rd_entry | output | VAL_W+1 (17) | Contents of slot rd_idx |
| listening | output | 1 | Run in progress; capture pulses are accepted |
| done | output | 1 | DEPTH measurements stored; further captures ignored |

## Verification
The bench targets four corner cases.

- Dropping the first capture. A design that stored it would shift every result one slot down, and it would finish one capture early.
- The downward address order, including the last write to slot 0. An off-by-one in the counter used as the write address would write slot 8 or stop at slot 1, leaving one slot at zero.
- Wrap handling in both formats, together with a mode flip in the middle of a run. A design that read ext_mode live would store bit 16, or drop a zeroed value, on the wrong entries.
- Arm and capture in the same cycle, and captures after done. Each of these, handled wrongly, would either change a slot that should hold its value or skip the discard of the first capture.

// File: rtl/pir_pkg.sv
package pir_pkg;

   typedef enum logic [1:0] {
      REC_IDLE  = 2'd0,
      REC_SKIP  = 2'd1,
      REC_STORE = 2'd2,
      REC_DONE  = 2'd3
   } rec_state_e;

endpackage

// File: rtl/pir_seq.sv
module pir_seq
   import pir_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1),
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             mode_in,
   input  logic             cap_valid,
   output logic             clr,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             mode_q,
   output logic             listening,
   output logic             done
);

   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   rec_state_e       state;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] remain_m1;

   assign remain_m1 = remain - CNT_LAST;
   assign clr       = arm;
   assign wr_en     = cap_valid && !arm && (state == REC_STORE);
   assign wr_idx    = IDX_W'(remain_m1);
   assign listening = (state == REC_SKIP) || (state == REC_STORE);
   assign done      = (state == REC_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= REC_IDLE;
         remain <= '0;
         mode_q <= 1'b0;
      end else if (arm) begin
         state  <= REC_SKIP;
         remain <= CNT_LOAD;
         mode_q <= mode_in;
      end else if (cap_valid) begin
         case (state)
            REC_SKIP: state <= REC_STORE;
            REC_STORE: begin
               remain <= remain_m1;
               if (remain == CNT_LAST) state <= REC_DONE;
            end
            default: ;
         endcase
      end
   end

   // R7: done holds until the next arm
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> done);

   // R7: never done and listening together
   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, listening}));

   // R4: each stored entry moves the write slot one step down
   p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (remain == $past(remain_m1)));

   // R2: arming starts a run with a full count
   p_arm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (listening && remain == CNT_LOAD));

endmodule

// File: rtl/pir_fmt.sv
module pir_fmt #(
   parameter int VAL_W  = 16,
   parameter bit EXT_EN = 1'b1
) (
   input  logic             ext,
   input  logic [VAL_W-1:0] value,
   input  logic             ovf,
   output logic [VAL_W:0]   entry
);

   logic [VAL_W:0] compact;

   assign compact = ovf ? '0 : {1'b0, value};

   generate
      if (EXT_EN) begin : g_ext
         assign entry = ext ? {ovf, value} : compact;
      end else begin : g_cmp
         logic unused_ext;
         assign unused_ext = ext;
         assign entry      = compact;
      end
   endgenerate

endmodule

// File: rtl/pir_buf.sv
module pir_buf #(
   parameter int DEPTH = 8,
   parameter int ENT_W = 17,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENT_W-1:0] rd_data
);

   logic [ENT_W-1:0] slot [DEPTH];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[gi] <= '0;
            else if (clr)
               slot[gi] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(gi)))
               slot[gi] <= wr_data;
         end

         // R2: clear empties every slot
         p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (slot[gi] == '0));
      end
   endgenerate

   assign rd_data = (int'(rd_idx) < DEPTH) ? slot[rd_idx] : '0;

   // R4: a write lands in the addressed slot on the next cycle
   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (slot[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/pulse_interval_recorder.sv
module pulse_interval_recorder #(
   parameter int VAL_W  = 16,
   parameter int DEPTH  = 8,
   parameter bit EXT_EN = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int ENT_W = VAL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             ext_mode,
   input  logic             cap_valid,
   input  logic [VAL_W-1:0] cap_value,
   input  logic             cap_ovf,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENT_W-1:0] rd_entry,
   output logic             listening,
   output logic             done
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pulse_interval_recorder: DEPTH must be at least 2");
      end
      if (VAL_W < 2) begin : g_bad_width
         $error("pulse_interval_recorder: VAL_W must be at least 2");
      end
   endgenerate

   logic             clr;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             mode_q;
   logic [ENT_W-1:0] wr_data;

   pir_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .mode_in   (ext_mode),
      .cap_valid (cap_valid),
      .clr       (clr),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .mode_q    (mode_q),
      .listening (listening),
      .done      (done)
   );

   pir_fmt #(.VAL_W(VAL_W), .EXT_EN(EXT_EN)) u_fmt (
      .ext   (mode_q),
      .value (cap_value),
      .ovf   (cap_ovf),
      .entry (wr_data)
   );

   pir_buf #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_entry)
   );

   // R8: no write is issued outside a run
   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!listening && !arm) |-> !wr_en);

endmodule

// File: tb/pulse_interval_recorder_test.sv
`timescale 1ns/1ps
module pulse_interval_recorder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        ext_mode = 1'b0;
   logic        cap_valid = 1'b0;
   logic [15:0] cap_value = '0;
   logic        cap_ovf = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [16:0] rd_entry;
   logic        listening;
   logic        done;

   always #5 clk = ~clk;

   pulse_interval_recorder uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .ext_mode(ext_mode),
      .cap_valid(cap_valid), .cap_value(cap_value), .cap_ovf(cap_ovf),
      .rd_idx(rd_idx), .rd_entry(rd_entry), .listening(listening), .done(done)
   );

   // behavioural reference
   logic [16:0] ref_mem [8];
   int          ref_st;      // 0 idle, 1 skip, 2 store, 3 done
   int          ref_left;
   bit          ref_ext;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 0;
   string req = "R1";

   task automatic cmp(input string what, input logic [16:0] act, input logic [16:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      cmp("done", {16'd0, done}, {16'd0, ref_st == 3});
      cmp("listening", {16'd0, listening}, {16'd0, (ref_st == 1 || ref_st == 2)});
      for (int i = 0; i < 8; i++) begin
         rd_idx = 3'(i);
         #0.2;
         cmp($sformatf("slot%0d", i), rd_entry, ref_mem[i]);
      end
   endtask

   task automatic model(input bit a, input bit m, input bit cv, input logic [15:0] v, input bit o);
      if (a) begin
         for (int i = 0; i < 8; i++) ref_mem[i] = '0;
         ref_left = 8;
         ref_ext  = m;
         ref_st   = 1;
      end else if (cv) begin
         if (ref_st == 1) ref_st = 2;
         else if (ref_st == 2) begin
            ref_mem[ref_left - 1] = ref_ext ? {o, v} : (o ? 17'd0 : {1'b0, v});
            ref_left--;
            if (ref_left == 0) ref_st = 3;
         end
      end
   endtask

   // called at a negedge; returns just after the next negedge check
   task automatic step(input bit a, input bit m, input bit cv, input logic [15:0] v, input bit o);
      arm = a; ext_mode = m; cap_valid = cv; cap_value = v; cap_ovf = o;
      @(posedge clk);
      model(a, m, cv, v, o);
      @(negedge clk);
      arm = 1'b0; cap_valid = 1'b0;
      check_all();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) ref_mem[i] = '0;
      ref_st = 0; ref_left = 0; ref_ext = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req = "R1";
      check_all();

      // R8: captures before any arm are ignored
      req = "R8";
      step(0, 0, 1, 16'h1234, 0);
      step(0, 1, 1, 16'hBEEF, 1);

      // R2 then R3: arm compact, first capture dropped
      req = "R2";
      step(1, 0, 0, 16'h0, 0);
      req = "R3";
      step(0, 0, 1, 16'hAAAA, 0);
      // R4 and R5: eight stores with boundary values and a wrap
      req = "R4";
      step(0, 0, 1, 16'h0006, 0);
      step(0, 0, 0, 16'h5555, 0);
      req = "R5";
      step(0, 0, 1, 16'hFFFF, 0);
      step(0, 0, 1, 16'h4321, 1);
      step(0, 0, 1, 16'h0100, 0);
      req = "R4";
      step(0, 0, 1, 16'h0200, 0);
      step(0, 0, 1, 16'h0300, 0);
      step(0, 0, 1, 16'h0400, 0);
      req = "R7";
      step(0, 0, 1, 16'h0500, 0);
      step(0, 0, 0, 16'h0, 0);
      // R8: captures after done are ignored
      req = "R8";
      step(0, 0, 1, 16'h7777, 0);
      step(0, 1, 1, 16'h8888, 1);

      // R6 and R9: extended run, ext_mode toggled during run
      req = "R2";
      step(1, 1, 0, 16'h0, 0);
      req = "R6";
      step(0, 1, 1, 16'h1111, 1);
      step(0, 1, 1, 16'hFFFF, 1);
      step(0, 1, 1, 16'h0006, 0);
      req = "R9";
      step(0, 0, 1, 16'h2222, 1);
      step(0, 0, 1, 16'h3333, 0);
      step(0, 0, 1, 16'h8000, 1);

      // R10: arm and capture together mid-run
      req = "R10";
      step(1, 0, 1, 16'h9999, 1);
      step(0, 0, 1, 16'hABCD, 0);
      step(0, 0, 1, 16'h0042, 0);
      for (int k = 0; k < 7; k++) begin
         req = (k == 6) ? "R7" : "R4";
         step(0, 1, 1, 16'(16'h1000 + k), (k == 3));
      end
      req = "R7";
      step(0, 0, 0, 16'h0, 0);
      step(0, 0, 0, 16'h0, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule